// File: doc/BRIEF.md
# Banked Control Register File with Indirect Window

This block is the small memory-mapped register space that sits beside an 8-bit controller core. The core presents an 8-bit data address in which bit 7 picks one of two banks and the low seven bits pick an offset. The core forms bit 7 from the bank bit the block itself exports. A handful of core registers are mirrored, so they are reached at the same offset from either bank. The remaining offsets are bank-specific. Offset 00h in either bank is a virtual window. It holds no storage and redirects the access to whatever location the 8-bit pointer register names.

Two port registers drive output latches and direction controls. Reading a port returns the live pin levels, not the latch. Timer, converter and interrupt registers are plain storage here. The block tells a power-on reset (asynchronous, active low) apart from any other reset (synchronous, active high). A cause input says whether that other reset came from a watchdog timeout. Each register has its own rule for which reset clears it and which leaves it alone.

There is no sequencing. All reads are combinational and every write lands on the next clock edge. For that reason the design has no state machine: its only "states" are the register contents.

Top module: `banked_sfr_file`

## Requirements
- R1: Bit 7 of `cpu_addr` selects the bank: offsets 00h–0Bh form bank 0 and 80h–8Bh form bank 1. `bank_o` reflects status bit 5, which is writable and cleared by every reset.
- R2: Offsets 02h (PC low), 03h (status), 04h (pointer), 09h (converter result), 0Ah (PC high latch) and 0Bh (interrupt control) reach the same storage from either bank.
- R3: An access to offset 00h or 80h reads or writes the location at the full 8-bit address held in the pointer register.
- R4: When the pointer's low seven bits are zero, an indirect access reads 00h and writes nothing.
- R5: Locations 07h, 87h, 0Ch–7Fh and 8Ch–FFh read 00h and ignore writes. Bits that are not implemented read 0: status 7:6, converter control bit 5, PC high 7:5, port A data and direction 7:5, and converter config 7:2.
- R6: A write to 05h or 06h sets that port's latch output. A read of 05h or 06h returns the pin inputs.
- R7: After power-on, status reads 18h, the option register (81h) reads FFh, direction A (85h) reads 1Fh and direction B (86h) reads FFh. Every other register reads 00h.
- R8: On a non-power-on reset, status bits 4:3 become 00 when `rst_wdt` is 1 and 11 otherwise. Bit 5 clears and bits 2:0 keep their value.
- R9: On a non-power-on reset, the following clear: PC low, PC high, converter control and config, port A latch bits 3:0, and interrupt control bits 7:1. Option returns to FFh and both direction registers return to all ones. The timer, pointer, result, port B latch, port A latch bit 4 and interrupt bit 0 keep their values.
- R10: Status bits 4:3 change only on a reset; writes to them and to bits 7:6 are ignored.
- R11: A non-power-on reset in the same cycle as a write wins; the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst | input | 1 | Other reset, synchronous, active high |
| rst_wdt | input | 1 | Cause of `sys_rst`: 1 = watchdog timeout |
| cpu_addr | input | 8 | Bank bit and offset of the access |
| cpu_we | input | 1 | Write enable |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| bank_o | output | 1 | Current bank bit |
| pin_a | input | PA_W | Port A pin levels |
| pin_b | input | PB_W | Port B pin levels |
| lat_a | output | PA_W | Port A output latch |
| lat_b | output | PB_W | Port B output latch |
| dir_a | output | PA_W | Port A direction, 1 = input |
| dir_b | output | PB_W | Port B direction, 1 = input |

## Verification
The bench walks every address in both banks. A decoder that failed to mirror a register, or that aliased a bank-0 location into bank 1, would return a stale or foreign byte. It drives the pointer to 00h and 80h. A design without the recursion guard would either write through to a real register or return pointer-dependent data. Non-power-on resets are issued with each cause and together with a write. A design that got this wrong would leave bits 4:3 set after a watchdog reset, lose a kept register such as the pointer, or let the write through. Pin levels are moved while the latches hold different values, so a port that returned its latch is caught.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [3:0] {
        RG_NONE, RG_TMR, RG_PCL, RG_STAT, RG_PTR, RG_PA, RG_PB, RG_ADCC,
        RG_ADRES, RG_PCH, RG_INTC, RG_OPT, RG_DIRA, RG_DIRB, RG_ADCF
    } reg_id_t;

    localparam logic [6:0] OFS_IND   = 7'h00;
    localparam logic [6:0] OFS_TMR   = 7'h01;
    localparam logic [6:0] OFS_PCL   = 7'h02;
    localparam logic [6:0] OFS_STAT  = 7'h03;
    localparam logic [6:0] OFS_PTR   = 7'h04;
    localparam logic [6:0] OFS_PORTA = 7'h05;
    localparam logic [6:0] OFS_PORTB = 7'h06;
    localparam logic [6:0] OFS_ADC   = 7'h08;
    localparam logic [6:0] OFS_ADRES = 7'h09;
    localparam logic [6:0] OFS_PCH   = 7'h0A;
    localparam logic [6:0] OFS_INTC  = 7'h0B;

    localparam int PCH_W = 5;
    localparam logic [7:0] OPT_RST    = 8'hFF;
    localparam logic [7:0] ADCC_MASK  = 8'hDF;
    localparam int ADCF_W = 2;
endpackage

// File: rtl/sfr_addr_resolve.sv
module sfr_addr_resolve (
    input  logic [7:0] cpu_addr,
    input  logic [7:0] ptr,
    output logic [7:0] eff_addr,
    output logic       blocked
);
    import sfr_pkg::*;
    logic is_window;

    // offset 00h in either bank is the virtual window
    assign is_window = (cpu_addr[6:0] == OFS_IND);
    assign eff_addr  = is_window ? ptr : cpu_addr;
    // a pointer at the window itself would recurse: block it
    assign blocked   = is_window && (ptr[6:0] == OFS_IND);
endmodule

// File: rtl/sfr_decode.sv
module sfr_decode (
    input  logic [7:0]       addr,
    input  logic             blocked,
    output sfr_pkg::reg_id_t id
);
    import sfr_pkg::*;

    always_comb begin
        id = RG_NONE;
        if (!blocked) begin
            // mirrored registers first: bank bit ignored
            case (addr[6:0])
                OFS_PCL:   id = RG_PCL;
                OFS_STAT:  id = RG_STAT;
                OFS_PTR:   id = RG_PTR;
                OFS_ADRES: id = RG_ADRES;
                OFS_PCH:   id = RG_PCH;
                OFS_INTC:  id = RG_INTC;
                OFS_TMR:   id = addr[7] ? RG_OPT  : RG_TMR;
                OFS_PORTA: id = addr[7] ? RG_DIRA : RG_PA;
                OFS_PORTB: id = addr[7] ? RG_DIRB : RG_PB;
                OFS_ADC:   id = addr[7] ? RG_ADCF : RG_ADCC;
                default:   id = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sfr_port.sv
module sfr_port #(
    parameter int           W        = 8,
    parameter logic [W-1:0] HOLD_MSK = '1
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst,
    input  logic         lat_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lat,
    output logic [W-1:0] dir
);
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (HOLD_MSK[i]) begin : g_keep
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)       lat_q[i] <= 1'b0;
                else if (sys_rst) lat_q[i] <= lat_q[i];
                else if (lat_we)  lat_q[i] <= wdata[i];
            end
        end else begin : g_clear
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)       lat_q[i] <= 1'b0;
                else if (sys_rst) lat_q[i] <= 1'b0;
                else if (lat_we)  lat_q[i] <= wdata[i];
            end
        end
    end

    // direction: every bit an input after any reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       dir_q <= '1;
        else if (sys_rst) dir_q <= '1;
        else if (dir_we)  dir_q <= wdata;
    end

    assign lat = lat_q;
    assign dir = dir_q;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!lat_we && !sys_rst) |=> $stable(lat));
    assert_dir_reset_R9: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (dir == {W{1'b1}}));
endmodule

// File: rtl/banked_sfr_file.sv
module banked_sfr_file #(
    parameter int PA_W = 5,
    parameter int PB_W = 8
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            sys_rst,
    input  logic            rst_wdt,
    input  logic [7:0]      cpu_addr,
    input  logic            cpu_we,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      cpu_rdata,
    output logic            bank_o,
    input  logic [PA_W-1:0] pin_a,
    input  logic [PB_W-1:0] pin_b,
    output logic [PA_W-1:0] lat_a,
    output logic [PB_W-1:0] lat_b,
    output logic [PA_W-1:0] dir_a,
    output logic [PB_W-1:0] dir_b
);
    import sfr_pkg::*;

    localparam logic [PA_W-1:0] PA_HOLD = PA_W'(1) << (PA_W - 1);
    localparam logic [PB_W-1:0] PB_HOLD = '1;

    logic [7:0]       eff_addr;
    logic             blocked;
    reg_id_t          id;
    logic             wr;

    logic [7:0]       tmr_q, pcl_q, ptr_q, adres_q, intc_q, opt_q, adcc_q;
    logic [PCH_W-1:0] pch_q;
    logic [ADCF_W-1:0] adcf_q;
    logic             st_bank;
    logic [1:0]       st_flags;
    logic [2:0]       st_low;

    sfr_addr_resolve u_resolve (
        .cpu_addr (cpu_addr),
        .ptr      (ptr_q),
        .eff_addr (eff_addr),
        .blocked  (blocked)
    );

    sfr_decode u_decode (
        .addr    (eff_addr),
        .blocked (blocked),
        .id      (id)
    );

    assign wr = cpu_we && !sys_rst;

    sfr_port #(.W(PA_W), .HOLD_MSK(PA_HOLD)) u_port_a (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .lat_we  (wr && id == RG_PA),
        .dir_we  (wr && id == RG_DIRA),
        .wdata   (cpu_wdata[PA_W-1:0]),
        .lat     (lat_a),
        .dir     (dir_a)
    );

    sfr_port #(.W(PB_W), .HOLD_MSK(PB_HOLD)) u_port_b (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .lat_we  (wr && id == RG_PB),
        .dir_we  (wr && id == RG_DIRB),
        .wdata   (cpu_wdata[PB_W-1:0]),
        .lat     (lat_b),
        .dir     (dir_b)
    );

    // core and peripheral storage: power-on, other reset, write
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q    <= '0;
            pcl_q    <= '0;
            ptr_q    <= '0;
            adres_q  <= '0;
            intc_q   <= '0;
            opt_q    <= OPT_RST;
            adcc_q   <= '0;
            pch_q    <= '0;
            adcf_q   <= '0;
            st_bank  <= 1'b0;
            st_flags <= 2'b11;
            st_low   <= '0;
        end else if (sys_rst) begin
            pcl_q    <= '0;
            intc_q   <= {7'b0, intc_q[0]};
            opt_q    <= OPT_RST;
            adcc_q   <= '0;
            pch_q    <= '0;
            adcf_q   <= '0;
            st_bank  <= 1'b0;
            st_flags <= rst_wdt ? 2'b00 : 2'b11;
        end else if (cpu_we) begin
            case (id)
                RG_TMR:   tmr_q   <= cpu_wdata;
                RG_PCL:   pcl_q   <= cpu_wdata;
                RG_PTR:   ptr_q   <= cpu_wdata;
                RG_ADRES: adres_q <= cpu_wdata;
                RG_INTC:  intc_q  <= cpu_wdata;
                RG_OPT:   opt_q   <= cpu_wdata;
                RG_ADCC:  adcc_q  <= cpu_wdata & ADCC_MASK;
                RG_PCH:   pch_q   <= cpu_wdata[PCH_W-1:0];
                RG_ADCF:  adcf_q  <= cpu_wdata[ADCF_W-1:0];
                RG_STAT: begin
                    st_bank <= cpu_wdata[5];
                    st_low  <= cpu_wdata[2:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (id)
            RG_TMR:   cpu_rdata = tmr_q;
            RG_PCL:   cpu_rdata = pcl_q;
            RG_STAT:  cpu_rdata = {2'b00, st_bank, st_flags, st_low};
            RG_PTR:   cpu_rdata = ptr_q;
            RG_PA:    cpu_rdata = 8'(pin_a);
            RG_PB:    cpu_rdata = 8'(pin_b);
            RG_ADCC:  cpu_rdata = adcc_q;
            RG_ADRES: cpu_rdata = adres_q;
            RG_PCH:   cpu_rdata = 8'(pch_q);
            RG_INTC:  cpu_rdata = intc_q;
            RG_OPT:   cpu_rdata = opt_q;
            RG_DIRA:  cpu_rdata = 8'(dir_a);
            RG_DIRB:  cpu_rdata = 8'(dir_b);
            RG_ADCF:  cpu_rdata = 8'(adcf_q);
            default:  cpu_rdata = 8'h00;
        endcase
    end

    assign bank_o = st_bank;

    assert_flags_readonly_R10: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst |=> $stable(st_flags));
    assert_blocked_nowrite_R4: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_we && blocked) |=> ($stable(ptr_q) && $stable(tmr_q) && $stable(st_low)
                                 && $stable(lat_b) && $stable(intc_q)));
    assert_bank_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> !bank_o);
    assert_reset_beats_write_R11: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && cpu_we) |=> ($stable(ptr_q) && $stable(tmr_q) && $stable(adres_q)));
    assert_wdt_flags_R8: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && rst_wdt) |=> (st_flags == 2'b00));
endmodule

// File: tb/banked_sfr_file_tb.sv
module banked_sfr_file_tb;
    localparam int PA_W = 5;
    localparam int PB_W = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sys_rst = 1'b0, rst_wdt = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic bank_o;
    logic [PA_W-1:0] pin_a = '0, lat_a, dir_a;
    logic [PB_W-1:0] pin_b = '0, lat_b, dir_b;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_tmr, m_pcl, m_ptr, m_adres, m_intc, m_opt, m_adcc, m_db, m_lb;
    logic [4:0] m_pch, m_la, m_da;
    logic [1:0] m_adcf, m_flags;
    logic [2:0] m_low;
    logic       m_bank;

    always #5 clk = ~clk;

    banked_sfr_file #(.PA_W(PA_W), .PB_W(PB_W)) u_dut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .rst_wdt(rst_wdt),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .bank_o(bank_o), .pin_a(pin_a), .pin_b(pin_b),
        .lat_a(lat_a), .lat_b(lat_b), .dir_a(dir_a), .dir_b(dir_b)
    );

    task automatic m_por();
        m_tmr = 0; m_pcl = 0; m_ptr = 0; m_adres = 0; m_intc = 0; m_opt = 8'hFF;
        m_adcc = 0; m_db = 8'hFF; m_lb = 0; m_pch = 0; m_la = 0; m_da = 5'h1F;
        m_adcf = 0; m_flags = 2'b11; m_low = 0; m_bank = 0;
    endtask

    task automatic m_sysrst(input bit wdt);
        m_pcl = 0; m_pch = 0; m_adcc = 0; m_adcf = 0; m_opt = 8'hFF;
        m_da = 5'h1F; m_db = 8'hFF; m_la[3:0] = 0; m_intc[7:1] = 0;
        m_bank = 0; m_flags = wdt ? 2'b00 : 2'b11;
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [7:0] ea = a;
        if (a[6:0] == 0) begin
            if (m_ptr[6:0] == 0) return 8'h00;
            ea = m_ptr;
        end
        case (ea[6:0])
            7'h02: return m_pcl;
            7'h03: return {2'b00, m_bank, m_flags, m_low};
            7'h04: return m_ptr;
            7'h09: return m_adres;
            7'h0A: return {3'b000, m_pch};
            7'h0B: return m_intc;
            7'h01: return ea[7] ? m_opt : m_tmr;
            7'h05: return ea[7] ? {3'b000, m_da} : {3'b000, pin_a};
            7'h06: return ea[7] ? m_db : pin_b;
            7'h08: return ea[7] ? {6'b0, m_adcf} : m_adcc;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] ea = a;
        if (a[6:0] == 0) begin
            if (m_ptr[6:0] == 0) return;
            ea = m_ptr;
        end
        case (ea[6:0])
            7'h02: m_pcl = d;
            7'h03: begin m_bank = d[5]; m_low = d[2:0]; end
            7'h04: m_ptr = d;
            7'h09: m_adres = d;
            7'h0A: m_pch = d[4:0];
            7'h0B: m_intc = d;
            7'h01: if (ea[7]) m_opt = d; else m_tmr = d;
            7'h05: if (ea[7]) m_da = d[4:0]; else m_la = d[4:0];
            7'h06: if (ea[7]) m_db = d; else m_lb = d;
            7'h08: if (ea[7]) m_adcf = d[1:0]; else m_adcc = d & 8'hDF;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // one cycle: drive, compare everything before the edge, update model after it
    task automatic op(input logic [7:0] a, input bit we, input logic [7:0] d,
                      input bit sr, input bit wdt, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_we = we; cpu_wdata = d; sys_rst = sr; rst_wdt = wdt;
        #1;
        chk(req, "rdata", cpu_rdata, m_read(a));
        chk(req, "lat_a", 8'(lat_a), 8'(m_la));
        chk(req, "lat_b", lat_b, m_lb);
        chk(req, "dir_a", 8'(dir_a), 8'(m_da));
        chk(req, "dir_b", dir_b, m_db);
        chk(req, "bank",  8'(bank_o), 8'(m_bank));
        @(posedge clk);
        #1;
        if (sr) m_sysrst(wdt);
        else if (we) m_write(a, d);
        cpu_we = 0; sys_rst = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        op(a, 1'b0, 8'h00, 1'b0, 1'b0, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        op(a, 1'b1, d, 1'b0, 1'b0, req);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 256; i++) rd(8'(i), req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_por();
        repeat (3) @(posedge clk);
        @(negedge clk) por_n = 1'b1;

        // R7 power-on values, R5 unimplemented space
        sweep("R7");
        rd(8'h03, "R7");
        rd(8'h81, "R7");

        // R1 R2 bank decode and mirrors
        wr(8'h01, 8'h5A, "R1");  rd(8'h81, "R1");  rd(8'h01, "R1");
        wr(8'h81, 8'h3C, "R1");  rd(8'h01, "R1");
        wr(8'h82, 8'hA5, "R2");  rd(8'h02, "R2");
        wr(8'h09, 8'h77, "R2");  rd(8'h89, "R2");
        wr(8'h8B, 8'hC3, "R2");  rd(8'h0B, "R2");
        wr(8'h8A, 8'hFF, "R5");  rd(8'h0A, "R5");
        wr(8'h08, 8'hFF, "R5");  rd(8'h08, "R5");
        wr(8'h88, 8'hFF, "R5");  rd(8'h88, "R5");
        wr(8'h85, 8'hEA, "R5");  rd(8'h85, "R5");

        // R10 status: reserved and flag bits ignore writes; bank bit follows
        wr(8'h03, 8'hFF, "R10"); rd(8'h83, "R10");
        wr(8'h83, 8'h00, "R10"); rd(8'h03, "R10");
        wr(8'h03, 8'h25, "R1");  rd(8'h03, "R1");

        // R6 ports: latch out, pins in
        wr(8'h05, 8'h15, "R6");  wr(8'h06, 8'h96, "R6");
        wr(8'h86, 8'h0F, "R6");
        pin_a = 5'h0A; pin_b = 8'h3E;
        rd(8'h05, "R6"); rd(8'h06, "R6");
        pin_a = 5'h1F; pin_b = 8'h01;
        rd(8'h05, "R6"); rd(8'h06, "R6");

        // R5 unimplemented locations ignore writes
        wr(8'h07, 8'hAA, "R5");  wr(8'h87, 8'hAA, "R5");
        wr(8'h40, 8'hAA, "R5");  wr(8'hC5, 8'hAA, "R5");
        wr(8'h0C, 8'hAA, "R5");  wr(8'hFF, 8'hAA, "R5");
        sweep("R5");

        // R3 indirect through the pointer, both banks
        wr(8'h04, 8'h09, "R3");  wr(8'h00, 8'h42, "R3");
        rd(8'h89, "R3");          rd(8'h80, "R3");
        wr(8'h84, 8'h86, "R3");  wr(8'h80, 8'h5A, "R3");
        rd(8'h86, "R3");          rd(8'h00, "R3");
        wr(8'h04, 8'h84, "R3");  wr(8'h00, 8'h01, "R3");
        rd(8'h04, "R3");          rd(8'h00, "R3");

        // R4 pointer at the window: reads zero, writes nothing
        wr(8'h04, 8'h00, "R4");  rd(8'h00, "R4");
        wr(8'h00, 8'hEE, "R4");  rd(8'h80, "R4");
        wr(8'h04, 8'h80, "R4");  wr(8'h80, 8'hEE, "R4");
        rd(8'h00, "R4");
        sweep("R4");

        // R8 R9 other reset, both causes
        wr(8'h04, 8'h33, "R9");  wr(8'h01, 8'h44, "R9");
        wr(8'h0B, 8'hFF, "R9");  wr(8'h05, 8'h1F, "R9");
        wr(8'h03, 8'h27, "R8");  wr(8'h02, 8'h12, "R9");
        op(8'h00, 1'b0, 8'h00, 1'b1, 1'b1, "R8");
        sweep("R8");
        wr(8'h03, 8'h05, "R8");
        op(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R8");
        sweep("R9");

        // R11 reset wins over a simultaneous write
        op(8'h04, 1'b1, 8'h99, 1'b1, 1'b0, "R11");
        rd(8'h04, "R11");
        op(8'h86, 1'b1, 8'h00, 1'b1, 1'b1, "R11");
        rd(8'h86, "R11"); rd(8'h03, "R11");

        // power-on again after activity
        @(negedge clk) por_n = 1'b0;
        m_por();
        @(negedge clk) por_n = 1'b1;
        sweep("R7");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule